// File: doc/BRIEF.md
# Paged Virtual Address Mapper

This block turns a 17-bit virtual word address into a 22-bit actual word address. The virtual space is split into 512-word pages. The upper eight address bits select one of 256 entries in a page map, and each entry supplies a 13-bit actual page number. The nine low bits pass straight through as the offset within the page. A status bit turns translation on or off. When it is off, the virtual address is zero-extended and used as the actual address.

Virtual word addresses 0 through 15 name the general registers and are never translated, in either mode. For these, the block raises a register-select flag instead. When translation is on, every translated request is also checked against two small per-page tables. The first holds a 2-bit access code. The second holds a 2-bit write lock, which is compared with a 2-bit write key taken from the status word. A request that fails either check raises a violation flag.

All three tables are filled through one load port. That port writes only while the privileged-mode input is high.

Top module: `vaddr_mapper`

## Requirements
- R1: Each response is registered. The outputs in the cycle after a clock edge reflect the request presented at that edge. When no request was presented, the response valid flag, address, register-select flag and violation flag are all zero.
- R2: A virtual address below 16 raises register select, whatever the state of map enable. It returns the zero-extended virtual address and never raises a violation. Address 16 is translated like any other address.
- R3: With map enable low, the actual address equals the zero-extended virtual address, and no violation is raised.
- R4: With map enable high, the actual address is {map[vaddr[16:9]], vaddr[8:0]}: the 13-bit table entry followed by the 9-bit offset.
- R5: The request kind is encoded as 00 read, 01 instruction fetch, 10 write and 11 read. The page access code is applied as follows: 00 permits every kind, 01 permits read and fetch, 10 permits read only, and 11 permits nothing. A request that is not permitted raises a violation.
- R6: A write with translation on is allowed only in three cases: the page lock is 00, the write key is 00, or the key equals the lock. Otherwise the write raises a violation. The lock has no effect on reads or fetches.
- R7: A load with load valid and privileged mode both high writes ldData into one table, selected by ldTable: 00 map (13 bits), 01 access code (ldData[1:0]), 10 write lock (ldData[1:0]), 11 nothing. The entry written is ldIndex. Requests in later cycles see the new value.
- R8: A load presented while privileged mode is low changes no table entry.
- R9: Reset sets every map entry, access code and write lock to zero, and clears all response outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Translation request present |
| reqVaddr | input | 17 | Virtual word address |
| reqKind | input | 2 | 00 read, 01 fetch, 10 write, 11 read |
| mapEnable | input | 1 | Translation enable from the status word |
| writeKey | input | 2 | Write key from the status word |
| ldValid | input | 1 | Table load strobe |
| ldPriv | input | 1 | Privileged mode; loads are dropped when low |
| ldTable | input | 2 | Target table: 00 map, 01 access, 10 lock, 11 none |
| ldIndex | input | 8 | Page entry to write |
| ldData | input | 13 | Load value (low 2 bits for the code tables) |
| rspValid | output | 1 | Response valid |
| rspAddr | output | 22 | Actual word address |
| rspRegSel | output | 1 | Address names a general register |
| rspViolation | output | 1 | Access or write-lock check failed |

## Verification
Every response appears one clock edge after its request. The bench therefore applies a request on a falling edge and compares all four outputs on the following falling edge. A load is applied on a falling edge and is written at the next rising edge, so the bench issues requests that depend on a load only in later cycles. The bench's page tables are updated at the same point. Idle cycles between operations let the bench confirm that all outputs return to zero.

// File: rtl/vmap_pkg.sv
package vmap_pkg;

  typedef enum logic [1:0] {
    KIND_READ  = 2'b00,
    KIND_FETCH = 2'b01,
    KIND_WRITE = 2'b10,
    KIND_RDALT = 2'b11
  } accKind_e;

  typedef enum logic [1:0] {
    TBL_MAP  = 2'b00,
    TBL_ACC  = 2'b01,
    TBL_LOCK = 2'b10,
    TBL_NONE = 2'b11
  } tblSel_e;

  typedef struct packed {
    logic wrMap;
    logic wrAcc;
    logic wrLock;
    logic regSel;
    logic xlate;
    logic deny;
  } ctrlStrobe_t;

endpackage

// File: rtl/vmap_ctrl.sv
module vmap_ctrl
  import vmap_pkg::*;
#(
  parameter int VA_W    = 17,
  parameter int REG_CNT = 16
) (
  input  logic [VA_W-1:0] reqVaddr,
  input  logic [1:0]      reqKind,
  input  logic            mapEnable,
  input  logic [1:0]      writeKey,
  input  logic [1:0]      curAcc,
  input  logic [1:0]      curLock,
  input  logic            ldValid,
  input  logic            ldPriv,
  input  logic [1:0]      ldTable,
  output ctrlStrobe_t     strobe
);

  localparam logic [VA_W-1:0] REG_LIMIT = VA_W'(REG_CNT);

  accKind_e kind;
  tblSel_e  tbl;
  logic     accOk;
  logic     lockOk;
  logic     ldGo;

  assign kind = accKind_e'(reqKind);
  assign tbl  = tblSel_e'(ldTable);
  assign ldGo = ldValid && ldPriv;

  always_comb begin
    unique case (curAcc)
      2'b00:   accOk = 1'b1;
      2'b01:   accOk = (kind != KIND_WRITE);
      2'b10:   accOk = (kind == KIND_READ) || (kind == KIND_RDALT);
      default: accOk = 1'b0;
    endcase
  end

  assign lockOk = (kind != KIND_WRITE) || (curLock == 2'b00) ||
                  (writeKey == 2'b00) || (writeKey == curLock);

  always_comb begin
    strobe        = '0;
    strobe.wrMap  = ldGo && (tbl == TBL_MAP);
    strobe.wrAcc  = ldGo && (tbl == TBL_ACC);
    strobe.wrLock = ldGo && (tbl == TBL_LOCK);
    strobe.regSel = (reqVaddr < REG_LIMIT);
    strobe.xlate  = mapEnable && !strobe.regSel;
    strobe.deny   = strobe.xlate && !(accOk && lockOk);
  end

endmodule

// File: rtl/vmap_dpath.sv
module vmap_dpath
  import vmap_pkg::*;
#(
  parameter int VA_W  = 17,
  parameter int OFF_W = 9,
  parameter int PPN_W = 13
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    reqValid,
  input  logic [VA_W-1:0]         reqVaddr,
  input  logic [VA_W-OFF_W-1:0]   ldIndex,
  input  logic [PPN_W-1:0]        ldData,
  input  ctrlStrobe_t             strobe,
  output logic [1:0]              curAcc,
  output logic [1:0]              curLock,
  output logic                    rspValid,
  output logic [PPN_W+OFF_W-1:0]  rspAddr,
  output logic                    rspRegSel,
  output logic                    rspViolation
);

  localparam int VPN_W = VA_W - OFF_W;
  localparam int PAGES = 1 << VPN_W;
  localparam int PA_W  = PPN_W + OFF_W;

  logic [PPN_W-1:0] mapTbl  [PAGES];
  logic [1:0]       accTbl  [PAGES];
  logic [1:0]       lockTbl [PAGES];

  logic [VPN_W-1:0] vpn;
  logic [PA_W-1:0]  xAddr;

  assign vpn     = reqVaddr[VA_W-1:OFF_W];
  assign curAcc  = accTbl[vpn];
  assign curLock = lockTbl[vpn];
  assign xAddr   = strobe.xlate ? {mapTbl[vpn], reqVaddr[OFF_W-1:0]}
                                : PA_W'(reqVaddr);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < PAGES; i++) begin
        mapTbl[i]  <= '0;
        accTbl[i]  <= '0;
        lockTbl[i] <= '0;
      end
    end else begin
      if (strobe.wrMap)  mapTbl[ldIndex]  <= ldData;
      if (strobe.wrAcc)  accTbl[ldIndex]  <= ldData[1:0];
      if (strobe.wrLock) lockTbl[ldIndex] <= ldData[1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rspValid     <= 1'b0;
      rspAddr      <= '0;
      rspRegSel    <= 1'b0;
      rspViolation <= 1'b0;
    end else begin
      rspValid     <= reqValid;
      rspAddr      <= reqValid ? xAddr : '0;
      rspRegSel    <= reqValid && strobe.regSel;
      rspViolation <= reqValid && strobe.deny;
    end
  end

endmodule

// File: rtl/vaddr_mapper.sv
module vaddr_mapper
  import vmap_pkg::*;
#(
  parameter int VA_W    = 17,
  parameter int OFF_W   = 9,
  parameter int PPN_W   = 13,
  parameter int REG_CNT = 16
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    reqValid,
  input  logic [VA_W-1:0]         reqVaddr,
  input  logic [1:0]              reqKind,
  input  logic                    mapEnable,
  input  logic [1:0]              writeKey,
  input  logic                    ldValid,
  input  logic                    ldPriv,
  input  logic [1:0]              ldTable,
  input  logic [VA_W-OFF_W-1:0]   ldIndex,
  input  logic [PPN_W-1:0]        ldData,
  output logic                    rspValid,
  output logic [PPN_W+OFF_W-1:0]  rspAddr,
  output logic                    rspRegSel,
  output logic                    rspViolation
);

  ctrlStrobe_t strobe;
  logic [1:0]  curAcc;
  logic [1:0]  curLock;

  vmap_ctrl #(.VA_W(VA_W), .REG_CNT(REG_CNT)) ctrl_i (
    .reqVaddr (reqVaddr),
    .reqKind  (reqKind),
    .mapEnable(mapEnable),
    .writeKey (writeKey),
    .curAcc   (curAcc),
    .curLock  (curLock),
    .ldValid  (ldValid),
    .ldPriv   (ldPriv),
    .ldTable  (ldTable),
    .strobe   (strobe)
  );

  vmap_dpath #(.VA_W(VA_W), .OFF_W(OFF_W), .PPN_W(PPN_W)) dpath_i (
    .clk         (clk),
    .rstN        (rstN),
    .reqValid    (reqValid),
    .reqVaddr    (reqVaddr),
    .ldIndex     (ldIndex),
    .ldData      (ldData),
    .strobe      (strobe),
    .curAcc      (curAcc),
    .curLock     (curLock),
    .rspValid    (rspValid),
    .rspAddr     (rspAddr),
    .rspRegSel   (rspRegSel),
    .rspViolation(rspViolation)
  );

endmodule

// File: rtl/vmap_chk.sv
module vmap_chk #(
  parameter int VA_W    = 17,
  parameter int OFF_W   = 9,
  parameter int PPN_W   = 13,
  parameter int REG_CNT = 16
) (
  input logic                    clk,
  input logic                    rstN,
  input logic                    reqValid,
  input logic [VA_W-1:0]         reqVaddr,
  input logic                    mapEnable,
  input logic                    rspValid,
  input logic [PPN_W+OFF_W-1:0]  rspAddr,
  input logic                    rspRegSel,
  input logic                    rspViolation
);

  localparam int PA_W = PPN_W + OFF_W;
  localparam logic [VA_W-1:0] REG_LIMIT = VA_W'(REG_CNT);

  // R1
  valid_follow_chk: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |=> rspValid);

  // R1
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    !reqValid |=> (!rspValid && rspAddr == '0 && !rspRegSel && !rspViolation));

  // R2
  reg_divert_chk: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqVaddr < REG_LIMIT) |=>
      (rspRegSel && !rspViolation && rspAddr == PA_W'($past(reqVaddr))));

  // R3
  pass_thru_chk: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && !mapEnable) |=>
      (!rspViolation && rspAddr == PA_W'($past(reqVaddr))));

  // R4
  offset_keep_chk: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |=> (rspAddr[OFF_W-1:0] == $past(reqVaddr[OFF_W-1:0])));

  // R2
  regsel_clean_chk: assert property (@(posedge clk) disable iff (!rstN)
    rspRegSel |-> (rspValid && !rspViolation));

endmodule

bind vaddr_mapper vmap_chk #(
  .VA_W(VA_W), .OFF_W(OFF_W), .PPN_W(PPN_W), .REG_CNT(REG_CNT)
) chk_i (
  .clk         (clk),
  .rstN        (rstN),
  .reqValid    (reqValid),
  .reqVaddr    (reqVaddr),
  .mapEnable   (mapEnable),
  .rspValid    (rspValid),
  .rspAddr     (rspAddr),
  .rspRegSel   (rspRegSel),
  .rspViolation(rspViolation)
);

// File: tb/vaddr_mapper_tb_top.sv
module vaddr_mapper_tb_top;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic [16:0] reqVaddr = '0;
  logic [1:0]  reqKind = '0;
  logic        mapEnable = 1'b0;
  logic [1:0]  writeKey = '0;
  logic        ldValid = 1'b0;
  logic        ldPriv = 1'b0;
  logic [1:0]  ldTable = '0;
  logic [7:0]  ldIndex = '0;
  logic [12:0] ldData = '0;
  logic        rspValid;
  logic [21:0] rspAddr;
  logic        rspRegSel;
  logic        rspViolation;

  int checks = 0;
  int errors = 0;

  logic [12:0] mapM  [256];
  logic [1:0]  accM  [256];
  logic [1:0]  lockM [256];

  always #5 clk = ~clk;

  vaddr_mapper dut_i (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqVaddr(reqVaddr),
    .reqKind(reqKind), .mapEnable(mapEnable), .writeKey(writeKey),
    .ldValid(ldValid), .ldPriv(ldPriv), .ldTable(ldTable),
    .ldIndex(ldIndex), .ldData(ldData), .rspValid(rspValid),
    .rspAddr(rspAddr), .rspRegSel(rspRegSel), .rspViolation(rspViolation)
  );

  function automatic logic [21:0] expAddr(logic [16:0] v, logic me);
    if (v < 17'd16 || !me) return {5'b0, v};
    return {mapM[v[16:9]], v[8:0]};
  endfunction

  function automatic logic expViol(logic [16:0] v, logic [1:0] k,
                                   logic me, logic [1:0] key);
    logic [1:0] a, l;
    logic aOk, lOk;
    if (v < 17'd16 || !me) return 1'b0;
    a = accM[v[16:9]];
    l = lockM[v[16:9]];
    case (a)
      2'b00:   aOk = 1'b1;
      2'b01:   aOk = (k != 2'b10);
      2'b10:   aOk = (k == 2'b00) || (k == 2'b11);
      default: aOk = 1'b0;
    endcase
    lOk = (k != 2'b10) || (l == 2'b00) || (key == 2'b00) || (key == l);
    return !(aOk && lOk);
  endfunction

  task automatic chk(input bit ok, input string tag,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic doLoad(input logic priv, input logic [1:0] tbl,
                        input logic [7:0] idx, input logic [12:0] d);
    @(negedge clk);
    ldValid = 1'b1; ldPriv = priv; ldTable = tbl; ldIndex = idx; ldData = d;
    @(negedge clk);
    ldValid = 1'b0; ldPriv = 1'b0;
    if (priv) begin
      case (tbl)
        2'b00: mapM[idx] = d;
        2'b01: accM[idx] = d[1:0];
        2'b10: lockM[idx] = d[1:0];
        default: ;
      endcase
    end
  endtask

  task automatic doReq(input logic [16:0] v, input logic [1:0] k,
                       input logic me, input logic [1:0] key,
                       input string tag);
    logic [21:0] ea;
    logic ev, er;
    ea = expAddr(v, me);
    ev = expViol(v, k, me, key);
    er = (v < 17'd16);
    @(negedge clk);
    reqValid = 1'b1; reqVaddr = v; reqKind = k; mapEnable = me; writeKey = key;
    @(negedge clk);
    reqValid = 1'b0;
    chk(rspValid == 1'b1, {tag, " valid"}, 32'(rspValid), 32'd1);
    chk(rspAddr == ea, {tag, " addr"}, 32'(rspAddr), 32'(ea));
    chk(rspRegSel == er, {tag, " regsel"}, 32'(rspRegSel), 32'(er));
    chk(rspViolation == ev, {tag, " viol"}, 32'(rspViolation), 32'(ev));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd2468));
    for (int i = 0; i < 256; i++) begin
      mapM[i] = '0; accM[i] = '0; lockM[i] = '0;
    end
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R9: outputs clear after reset
    chk(rspValid == 0 && rspAddr == 0 && !rspRegSel && !rspViolation,
        "R9 reset outputs", 32'(rspAddr), 32'd0);
    // R9: tables cleared (entry zero, code 00, lock 00)
    doReq({8'd3, 9'd5}, 2'b10, 1'b1, 2'b01, "R9 cleared tables");
    chk(rspAddr == 22'd5, "R9 map entry zero", 32'(rspAddr), 32'd5);

    // R8: unprivileged loads dropped
    doLoad(1'b0, 2'b00, 8'd3, 13'h1ABC);
    doLoad(1'b0, 2'b01, 8'd3, 13'h0003);
    doReq({8'd3, 9'd7}, 2'b00, 1'b1, 2'b00, "R8 unpriv");
    chk(rspAddr == 22'd7 && !rspViolation, "R8 table untouched",
        32'(rspAddr), 32'd7);

    // R7 / R4: privileged map load, maximum page and offset
    doLoad(1'b1, 2'b00, 8'd3, 13'h1FFF);
    doReq({8'd3, 9'h1FF}, 2'b00, 1'b1, 2'b00, "R4 max page");
    chk(rspAddr == 22'h3FFFFF, "R7 loaded map", 32'(rspAddr), 32'h3FFFFF);
    doLoad(1'b1, 2'b11, 8'd3, 13'h0000);
    doReq({8'd3, 9'h010}, 2'b00, 1'b1, 2'b00, "R7 table code none");

    // R2: register diversion boundary
    doReq(17'd15, 2'b10, 1'b1, 2'b01, "R2 addr 15");
    doReq(17'd0, 2'b01, 1'b0, 2'b00, "R2 addr 0 map off");
    doReq(17'd16, 2'b00, 1'b1, 2'b00, "R2 addr 16");

    // R3: passthrough ignores protection
    doLoad(1'b1, 2'b01, 8'd255, 13'h0003);
    doReq(17'h1FFFF, 2'b10, 1'b0, 2'b11, "R3 passthru max");
    chk(rspAddr == 22'h01FFFF && !rspViolation, "R3 direct",
        32'(rspAddr), 32'h1FFFF);
    doReq(17'h1FFFF, 2'b00, 1'b1, 2'b00, "R5 code 11 read");

    // R5: access codes on page 4
    doLoad(1'b1, 2'b01, 8'd4, 13'h0001);
    doReq({8'd4, 9'd1}, 2'b10, 1'b1, 2'b00, "R5 code 01 write");
    doReq({8'd4, 9'd2}, 2'b01, 1'b1, 2'b00, "R5 code 01 fetch");
    doLoad(1'b1, 2'b01, 8'd4, 13'h0002);
    doReq({8'd4, 9'd3}, 2'b01, 1'b1, 2'b00, "R5 code 10 fetch");
    doReq({8'd4, 9'd4}, 2'b11, 1'b1, 2'b00, "R5 code 10 read alt");

    // R6: write lock on page 6
    doLoad(1'b1, 2'b10, 8'd6, 13'h0002);
    doReq({8'd6, 9'd0}, 2'b10, 1'b1, 2'b01, "R6 key mismatch");
    chk(rspViolation == 1'b1, "R6 blocked", 32'(rspViolation), 32'd1);
    doReq({8'd6, 9'd0}, 2'b10, 1'b1, 2'b10, "R6 key match");
    doReq({8'd6, 9'd0}, 2'b10, 1'b1, 2'b00, "R6 key zero");
    doReq({8'd6, 9'd0}, 2'b00, 1'b1, 2'b01, "R6 read unaffected");

    // R1: idle cycle clears outputs
    @(negedge clk);
    chk(!rspValid && rspAddr == 0 && !rspViolation, "R1 idle",
        32'(rspValid), 32'd0);

    // Random mix
    for (int n = 0; n < 400; n++) begin
      int sel;
      logic [7:0] pg;
      sel = int'($urandom % 4);
      pg = ($urandom % 2 == 0) ? 8'($urandom % 8) : 8'($urandom);
      if (sel == 0) begin
        doLoad(($urandom % 5) != 0, 2'($urandom), pg, 13'($urandom));
      end else begin
        logic [16:0] v;
        v = ($urandom % 8 == 0) ? 17'($urandom % 32)
                                : {pg, 9'($urandom)};
        doReq(v, 2'($urandom % 3), 1'($urandom), 2'($urandom), "R1 R4 R5 R6 random");
      end
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule